// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Pin-Level Mode Control

This block is a synthesizable behavioural model of a byte-wide memory that can be programmed only once. It is controlled by pins. A chip-enable, an output-enable and a program strobe (all active low) work with two level flags: one says the programming supply is at its high level, the other says the identify address line carries its high voltage. Together these pins select one operating mode:

- read
- output disable
- standby
- program
- program verify
- program inhibit
- auto-identify

The bidirectional byte bus is split into a data input, a data output and an output-drive enable. A testbench or a larger system model can drive the pins much as a device programmer or a host bus would.

Every input passes through a synchroniser of `SYNC_STAGES` flops. The mode is then decoded and registered, together with the output byte and its drive enable. The array starts fully erased, with every bit at one. A program operation takes effect when the program strobe is released. It stores the bitwise AND of the old and new byte, so repeated attempts can only clear bits. The decoded mode is visible on a debug port.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset every array location reads 0xFF. A program operation stores (old AND new), so no bit ever returns from 0 to 1. Addresses that are not programmed keep their value.
- R2: Read mode (debug code 2) requires chip-enable low, output-enable low, programming supply flag low and identify flag low. In this mode the stored byte at the address is driven and `dout_en_o` is 1.
- R3: With chip-enable high the output is not driven, whatever output-enable is. The debug code is 0 (standby) when the supply flag is low and 6 (inhibit) when it is high. A program strobe pulse in this state leaves the array unchanged.
- R4: Program mode (debug code 4) requires chip-enable low, output-enable high, program strobe low and supply flag high. The output is not driven.
- R5: Program verify (debug code 5) requires chip-enable low, output-enable low, program strobe high and supply flag high. The stored byte is driven.
- R6: Auto-identify (debug code 3) requires chip-enable low, output-enable low, supply flag low and identify flag high. The output is 0xC2 when address bit 0 is 0 and 0xCA when it is 1.
- R7: Output disable (debug code 1) covers every other combination with chip-enable low. This includes output-enable high, and also output-enable low with the strobe low and the supply flag high. The output is not driven.
- R8: A program operation commits only on the rising edge of the synchronised program strobe that ends a program-mode interval. It uses the address and data latched during that interval.
- R9: A change on the inputs first appears on `mode_o`, `dout_o` and `dout_en_o` at the (SYNC_STAGES+1)-th rising clock edge after it. Until then the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| addr_i | input | ADDR_W | Byte address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| pgm_n_i | input | 1 | Program strobe, active low |
| vpp_prog_i | input | 1 | Programming supply at high level |
| a9_hv_i | input | 1 | Identify address line at high voltage |
| din_i | input | DATA_W | Byte to program |
| dout_o | output | DATA_W | Output byte (0 when not driven) |
| dout_en_o | output | 1 | Output byte is driven |
| mode_o | output | 3 | Decoded mode code |

## Verification
The checker runs on every cycle. It checks the following:
- a deselected chip never drives the bus;
- a driven bus always follows a sample with both enables low;
- a commit happens only on a strobe rise with the chip selected and the supply high, and it never raises a bit at the programmed address;
- auto-identify only ever presents one of the two codes.

Whether the stored value is the exact AND of the old and new byte, and whether inhibited strobes and neighbouring addresses leave data alone, can only be shown by the bench scenarios. The same holds for the exact latency of a mode change. These scenarios program, retry, verify and read back specific locations.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_DISABLE = 3'd1,
        MD_READ    = 3'd2,
        MD_IDENT   = 3'd3,
        MD_PROGRAM = 3'd4,
        MD_VERIFY  = 3'd5,
        MD_INHIBIT = 3'd6
    } otp_mode_e;

    localparam logic [7:0] ID_MFR_CODE = 8'hC2;
    localparam logic [7:0] ID_DEV_CODE = 8'hCA;

endpackage

// File: rtl/otp_sync.sv
module otp_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      pgm_n,
    input  logic      vpp_prog,
    input  logic      a9_hv,
    output otp_mode_e mode
);

    always_comb begin
        if (ce_n) begin
            mode = vpp_prog ? MD_INHIBIT : MD_STANDBY;
        end else if (oe_n) begin
            mode = (vpp_prog && !pgm_n) ? MD_PROGRAM : MD_DISABLE;
        end else if (vpp_prog) begin
            mode = pgm_n ? MD_VERIFY : MD_DISABLE;
        end else begin
            mode = a9_hv ? MD_IDENT : MD_READ;
        end
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wr_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[wr_addr] <= mem_q[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign wr_word = mem_q[wr_addr];

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
    import otp_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              pgm_n_i,
    input  logic              vpp_prog_i,
    input  logic              a9_hv_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o,
    output logic [2:0]        mode_o
);

    localparam int CTL_W = 5;
    localparam int IN_W  = CTL_W + ADDR_W + DATA_W;
    localparam logic [IN_W-1:0] IN_RST = {5'b11100, {(ADDR_W + DATA_W){1'b0}}};
    localparam logic [DATA_W-1:0] MFR_W = DATA_W'(ID_MFR_CODE);
    localparam logic [DATA_W-1:0] DEV_W = DATA_W'(ID_DEV_CODE);

    typedef struct packed {
        otp_mode_e         mode;
        logic [DATA_W-1:0] dout;
        logic              doe;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
    } state_t;

    logic [IN_W-1:0]   raw_in;
    logic [IN_W-1:0]   syn_in;
    logic              s_ce_n;
    logic              s_oe_n;
    logic              s_pgm_n;
    logic              s_vpp;
    logic              s_hv;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din;
    otp_mode_e         dec_mode;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] wr_word;
    logic              wr_en;
    state_t            st_d;
    state_t            st_q;

    assign raw_in = {ce_n_i, oe_n_i, pgm_n_i, vpp_prog_i, a9_hv_i, addr_i, din_i};

    otp_sync #(
        .W      (IN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_in),
        .q_o  (syn_in)
    );

    assign {s_ce_n, s_oe_n, s_pgm_n, s_vpp, s_hv, s_addr, s_din} = syn_in;

    otp_mode_dec u_dec (
        .ce_n    (s_ce_n),
        .oe_n    (s_oe_n),
        .pgm_n   (s_pgm_n),
        .vpp_prog(s_vpp),
        .a9_hv   (s_hv),
        .mode    (dec_mode)
    );

    // Commit when the strobe rises out of a program interval.
    assign wr_en = (st_q.mode == MD_PROGRAM) && s_pgm_n;

    otp_cell_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(st_q.paddr),
        .wr_data(st_q.pdata),
        .rd_addr(s_addr),
        .rd_data(rd_data),
        .wr_word(wr_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = dec_mode;
        st_d.dout = '0;
        st_d.doe  = 1'b0;
        case (dec_mode)
            MD_READ, MD_VERIFY: begin
                st_d.dout = rd_data;
                st_d.doe  = 1'b1;
            end
            MD_IDENT: begin
                st_d.dout = s_addr[0] ? DEV_W : MFR_W;
                st_d.doe  = 1'b1;
            end
            MD_PROGRAM: begin
                st_d.paddr = s_addr;
                st_d.pdata = s_din;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_STANDBY, dout: '0, doe: 1'b0, paddr: '0, pdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o    = st_q.dout;
    assign dout_en_o = st_q.doe;
    assign mode_o    = st_q.mode;

endmodule

// File: rtl/otp_byte_mem_chk.sv
module otp_byte_mem_chk
    import otp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ce_n,
    input logic              s_oe_n,
    input logic              s_pgm_n,
    input logic              s_vpp,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_word,
    input logic [2:0]        mode_o,
    input logic [DATA_W-1:0] dout_o,
    input logic              dout_en_o
);

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        s_ce_n |=> !dout_en_o); // R3

    AST_DRIVE_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en_o |-> (!$past(s_ce_n) && !$past(s_oe_n))); // R2

    AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $rose(s_pgm_n)); // R8

    AST_COMMIT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!$past(s_ce_n) && $past(s_vpp))); // R4

    AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((wr_word & ~$past(wr_word)) == '0)); // R1

    AST_IDENT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_IDENT) |-> (dout_en_o &&
            ((dout_o == DATA_W'(ID_MFR_CODE)) || (dout_o == DATA_W'(ID_DEV_CODE))))); // R6

endmodule

bind otp_byte_mem otp_byte_mem_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_ce_n   (s_ce_n),
    .s_oe_n   (s_oe_n),
    .s_pgm_n  (s_pgm_n),
    .s_vpp    (s_vpp),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .mode_o   (mode_o),
    .dout_o   (dout_o),
    .dout_en_o(dout_en_o)
);

// File: tb/tb_otp_byte_mem.sv
`timescale 1ns/1ps
module tb_otp_byte_mem;

    localparam int AW = 11;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          pgm_n = 1'b1;
    logic          vpp = 1'b0;
    logic          hv = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic [2:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [DW-1:0] dout;
        logic          oe;
        logic [2:0]    mode;
        string         tag;
    } exp_t;

    exp_t sbq[$];

    always #4 clk = ~clk;

    otp_byte_mem #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .ce_n_i    (ce_n),
        .oe_n_i    (oe_n),
        .pgm_n_i   (pgm_n),
        .vpp_prog_i(vpp),
        .a9_hv_i   (hv),
        .din_i     (din),
        .dout_o    (dout),
        .dout_en_o (dout_en),
        .mode_o    (mode)
    );

    task automatic drive(input logic c, input logic o, input logic p, input logic v,
                         input logic h, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk);
        #1;
        ce_n = c; oe_n = o; pgm_n = p; vpp = v; hv = h; addr = a; din = d;
    endtask

    task automatic expect_after(input int n, input logic [DW-1:0] d, input logic o,
                                input logic [2:0] m, input string tag);
        exp_t e;
        repeat (n) @(posedge clk);
        #1;
        e.dout = d; e.oe = o; e.mode = m; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: compare between edges.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if ((dout_en !== e.oe) || (mode !== e.mode) || (e.oe && (dout !== e.dout))) begin
                    errors++;
                    $display("FAIL %s: got dout=%h en=%b mode=%0d, expected dout=%h en=%b mode=%0d",
                             e.tag, dout, dout_en, mode, e.dout, e.oe, e.mode);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic program_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        drive(0, 1, 0, 1, 0, a, d);
        expect_after(4, 8'h00, 0, 3'd4, tag);
        drive(0, 1, 1, 1, 0, a, d);
        expect_after(4, 8'h00, 0, 3'd1, tag);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3: idle after reset is standby, not driven
        expect_after(3, 8'h00, 0, 3'd0, "R3 reset standby");

        // R1 / R2: erased array reads all ones
        drive(0, 0, 1, 0, 0, 11'd0, 8'h00);
        expect_after(4, 8'hFF, 1, 3'd2, "R1 erased read addr0");

        // R9: output-enable release takes SYNC_STAGES+1 edges
        drive(0, 1, 1, 0, 0, 11'd0, 8'h00);
        expect_after(2, 8'hFF, 1, 3'd2, "R9 old mode held");
        expect_after(1, 8'h00, 0, 3'd1, "R9 new mode at third edge");
        expect_after(1, 8'h00, 0, 3'd1, "R7 output disable");

        // R3: chip deselected with output-enable low
        drive(1, 0, 1, 0, 0, 11'd0, 8'h00);
        expect_after(4, 8'h00, 0, 3'd0, "R3 standby ignores oe");

        // R4 / R5: program then verify
        program_byte(11'd5, 8'hA5, "R4 program addr5");
        drive(0, 0, 1, 1, 0, 11'd5, 8'h00);
        expect_after(4, 8'hA5, 1, 3'd5, "R5 verify addr5");

        // R8: retry stores old AND new
        program_byte(11'd5, 8'h5A, "R8 retry program");
        drive(0, 0, 1, 1, 0, 11'd5, 8'h00);
        expect_after(4, 8'h00, 1, 3'd5, "R8 retry result AND");

        // R2: normal read of programmed byte
        drive(0, 0, 1, 0, 0, 11'd5, 8'h00);
        expect_after(4, 8'h00, 1, 3'd2, "R2 read addr5");

        // R1: neighbours untouched
        drive(0, 0, 1, 0, 0, 11'd4, 8'h00);
        expect_after(4, 8'hFF, 1, 3'd2, "R1 addr4 untouched");
        drive(0, 0, 1, 0, 0, 11'd6, 8'h00);
        expect_after(4, 8'hFF, 1, 3'd2, "R1 addr6 untouched");

        // R3: inhibited strobe writes nothing
        drive(1, 1, 0, 1, 0, 11'd7, 8'h00);
        expect_after(4, 8'h00, 0, 3'd6, "R3 inhibit mode");
        drive(1, 1, 1, 1, 0, 11'd7, 8'h00);
        expect_after(4, 8'h00, 0, 3'd6, "R3 inhibit release");
        drive(0, 0, 1, 0, 0, 11'd7, 8'h00);
        expect_after(4, 8'hFF, 1, 3'd2, "R3 addr7 unchanged");

        // R6: identify codes
        drive(0, 0, 1, 0, 1, 11'd0, 8'h00);
        expect_after(4, 8'hC2, 1, 3'd3, "R6 maker code");
        drive(0, 0, 1, 0, 1, 11'd1, 8'h00);
        expect_after(4, 8'hCA, 1, 3'd3, "R6 device code");

        // R7: both enables low, strobe low, supply high -> disable
        drive(0, 0, 0, 1, 0, 11'd9, 8'h00);
        expect_after(4, 8'h00, 0, 3'd1, "R7 strobe low with oe low");
        drive(0, 0, 1, 0, 0, 11'd9, 8'h00);
        expect_after(4, 8'hFF, 1, 3'd2, "R8 no commit outside program");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule